// File: doc/BRIEF.md
# Link Packet Transmitter with Wait Pushback

This block sends mesh transactions over a narrow link. Three sources offer 104-bit transactions through valid/ready handshakes: read responses, writes and read requests. A fixed-priority arbiter picks one. A serializer then sends it one byte per link clock, with a frame signal that is high for exactly the bytes of the packet. A header byte comes first, then the destination address, then one data word. A 64-bit write adds a second word.

The far end pushes back with two wait inputs, one for reads and one for writes. Their phase is unknown, so each passes through a two-flop synchronizer in the transmit clock domain. A synchronized wait only stops a packet of its class from starting. A packet already on the wire always finishes, and a source whose class is held back is skipped, so other traffic keeps flowing. Frame always returns low for at least one cycle between packets.

The serializer state machine has three states:
- `ST_IDLE`: frame is low and the arbiter may grant.
- `ST_HEAD`: byte0 is on the link.
- `ST_BODY`: bytes 1 to the last are on the link.

It has four transitions:
- IDLE→HEAD when a grant is accepted.
- HEAD→BODY always.
- BODY→BODY while bytes remain.
- BODY→IDLE after the last byte.

Top module: `link_tx`

## Requirements
- R1: While reset is asserted and after it is released with no valid input, `link_frame` is 0, `link_byte` is 0 and all three ready outputs are 0.
- R2: Each transaction input is laid out as bit 0 access (ignored), bit 1 write, bits 3:2 datamode (00=8, 01=16, 10=32, 11=64 bits), bits 7:4 ctrlmode, bits 39:8 destination address, bits 71:40 data, and bits 103:72 source address.
- R3: `link_frame` rises together with byte0. Byte0 is {ctrlmode[3:0], datamode[1:0], write, long}, where long is 1 exactly when write=1 and datamode=11.
- R4: Bytes 1-4 carry the destination address, most significant byte first. Bytes 5-8 carry the data word when write=1 and the source address (return address) when write=0, also most significant byte first. A packet with long=0 is 9 bytes.
- R5: A packet with long=1 is 13 bytes, and bytes 9-12 carry the source address (upper data word), most significant byte first.
- R6: `link_frame` is low for at least one cycle between packets. At most one ready output is high in any cycle, and ready is only given while no packet is being sent.
- R7: When several sources are eligible at once, the read response is granted first, then the write, then the read request.
- R8: `rd_wait_async` passes through two flops. A level applied before one clock edge does not yet block, but after two edges no read request is granted while it stays high.
- R9: Once `wr_wait_async` has been synchronized high, neither a write nor a read response is granted.
- R10: A source whose class is held back by a wait is skipped, and an eligible source of the other class is granted instead.
- R11: A packet that has started is sent to its last byte even if a wait rises while it is in flight.
- R12: Byte0 of a granted transaction appears on the link in the cycle right after the clock edge at which valid and ready were both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_valid | input | 1 | Read response transaction offered |
| rr_ready | output | 1 | Read response accepted this edge |
| rr_txn | input | 104 | Read response transaction |
| wr_valid | input | 1 | Write transaction offered |
| wr_ready | output | 1 | Write accepted this edge |
| wr_txn | input | 104 | Write transaction |
| rq_valid | input | 1 | Read request transaction offered |
| rq_ready | output | 1 | Read request accepted this edge |
| rq_txn | input | 104 | Read request transaction |
| rd_wait_async | input | 1 | Read pushback from far end, any phase |
| wr_wait_async | input | 1 | Write pushback from far end, any phase |
| link_frame | output | 1 | High for each byte of a packet |
| link_byte | output | 8 | Link data byte |

## Verification
The serializer is driven with three kinds of packet:
- A 32-bit write, which shows the data word in bytes 5-8.
- A read request, which shows the source address in bytes 5-8.
- A 64-bit write, which shows the 13-byte length and the header long bit.

All three sources are offered at once to expose the priority order and the idle gap between back-to-back packets. The read wait is raised one edge and then two edges before a request appears. This tells a two-flop synchronizer apart from a shorter or longer one. Each wait is held while the other class is offered, which shows that blocked sources are skipped rather than stalling the link. A wait raised during a long packet shows that the packet is not cut short.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

    localparam int TXN_W       = 104;
    localparam int NSRC        = 3;
    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 32;
    localparam int WORD_BYTES  = WORD_W / BYTE_W;
    localparam int SHORT_BYTES = 1 + 2 * WORD_BYTES;
    localparam int MAX_BYTES   = 1 + 3 * WORD_BYTES;
    localparam int SYNC_STAGES = 2;

    // Source index doubles as priority: lower index wins.
    localparam int SRC_RR = 0;
    localparam int SRC_WR = 1;
    localparam int SRC_RQ = 2;

    localparam logic [1:0] DM_64 = 2'b11;

    typedef struct packed {
        logic [WORD_W-1:0] srcaddr;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] dstaddr;
        logic [3:0]        ctrlmode;
        logic [1:0]        datamode;
        logic              write;
        logic              access;
    } txn_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } ser_state_e;

endpackage

// File: rtl/link_tx_sync.sv
module link_tx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/link_tx_arb.sv
module link_tx_arb #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] blocked,
    output logic [NSRC-1:0] grant
);

    logic [NSRC-1:0] eligible;
    logic [NSRC:0]   taken;

    assign eligible = req & ~blocked;
    assign taken[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_prio
            assign grant[i]   = eligible[i] & ~taken[i];
            assign taken[i+1] = taken[i] | eligible[i];
        end
    endgenerate

endmodule

// File: rtl/link_tx_ser.sv
module link_tx_ser
    import link_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  txn_t              load_txn,
    output logic              idle,
    output logic              frame,
    output logic [BYTE_W-1:0] byte_out
);

    localparam int IDX_W = $clog2(MAX_BYTES);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(MAX_BYTES - 1);

    ser_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    txn_t              cur;
    logic              is_long;
    logic [IDX_W-1:0]  last_idx;
    logic [WORD_W-1:0] mid_word;
    logic [BYTE_W-1:0] pkt_bytes [MAX_BYTES];

    assign is_long  = cur.write && (cur.datamode == DM_64);
    assign last_idx = is_long ? LAST_LONG : LAST_SHORT;
    assign mid_word = cur.write ? cur.data : cur.srcaddr;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (load) state_nx = ST_HEAD;
            ST_HEAD: state_nx = ST_BODY;
            ST_BODY: if (idx == last_idx) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and packet holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            cur   <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (load) cur <= load_txn;
                end
                ST_HEAD: idx <= IDX_W'(1);
                ST_BODY: idx <= (idx == last_idx) ? '0 : idx + IDX_W'(1);
                default: idx <= '0;
            endcase
        end
    end

    // Byte layout of the packet
    always_comb begin
        pkt_bytes[0] = {cur.ctrlmode, cur.datamode, cur.write, is_long};
        for (int k = 0; k < WORD_BYTES; k++) begin
            pkt_bytes[1 + k]                = cur.dstaddr[BYTE_W*(WORD_BYTES-1-k) +: BYTE_W];
            pkt_bytes[1 + WORD_BYTES + k]   = mid_word[BYTE_W*(WORD_BYTES-1-k) +: BYTE_W];
            pkt_bytes[1 + 2*WORD_BYTES + k] = cur.srcaddr[BYTE_W*(WORD_BYTES-1-k) +: BYTE_W];
        end
    end

    // Outputs
    always_comb begin
        idle     = 1'b0;
        frame    = 1'b0;
        byte_out = '0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_HEAD: begin
                frame    = 1'b1;
                byte_out = pkt_bytes[0];
            end
            ST_BODY: begin
                frame    = 1'b1;
                byte_out = pkt_bytes[idx];
            end
            default: idle = 1'b1;
        endcase
    end

    AST_HEAD_THEN_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD) |=> (state == ST_BODY)); // R11
    AST_BODY_RUNS_TO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && idx != last_idx) |=> (frame && idx == $past(idx) + IDX_W'(1))); // R11
    AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && idx == last_idx) |=> !frame); // R6
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !frame); // R6

endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_valid,
    output logic              rr_ready,
    input  logic [TXN_W-1:0]  rr_txn,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [TXN_W-1:0]  wr_txn,
    input  logic              rq_valid,
    output logic              rq_ready,
    input  logic [TXN_W-1:0]  rq_txn,
    input  logic              rd_wait_async,
    input  logic              wr_wait_async,
    output logic              link_frame,
    output logic [BYTE_W-1:0] link_byte
);

    logic [1:0]       wait_sync;
    logic             rd_wait_s, wr_wait_s;
    logic [NSRC-1:0]  req, blocked, grant, ready_vec;
    logic [TXN_W-1:0] src_txn [NSRC];
    txn_t             sel_txn;
    logic             ser_idle, load;

    link_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({wr_wait_async, rd_wait_async}),
        .sync_out (wait_sync)
    );

    assign rd_wait_s = wait_sync[0];
    assign wr_wait_s = wait_sync[1];

    // Read responses travel as writes on the link, so write wait holds them too.
    always_comb begin
        req             = '0;
        blocked         = '0;
        req[SRC_RR]     = rr_valid;
        req[SRC_WR]     = wr_valid;
        req[SRC_RQ]     = rq_valid;
        blocked[SRC_RR] = wr_wait_s;
        blocked[SRC_WR] = wr_wait_s;
        blocked[SRC_RQ] = rd_wait_s;
    end

    assign src_txn[SRC_RR] = rr_txn;
    assign src_txn[SRC_WR] = wr_txn;
    assign src_txn[SRC_RQ] = rq_txn;

    link_tx_arb #(.NSRC(NSRC)) u_arb (
        .req     (req),
        .blocked (blocked),
        .grant   (grant)
    );

    assign ready_vec = grant & {NSRC{ser_idle}};
    assign load      = |ready_vec;
    assign rr_ready  = ready_vec[SRC_RR];
    assign wr_ready  = ready_vec[SRC_WR];
    assign rq_ready  = ready_vec[SRC_RQ];

    always_comb begin
        sel_txn = '0;
        for (int i = 0; i < NSRC; i++)
            if (grant[i]) sel_txn = txn_t'(src_txn[i]);
    end

    link_tx_ser u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_txn (sel_txn),
        .idle     (ser_idle),
        .frame    (link_frame),
        .byte_out (link_byte)
    );

    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rr_ready, wr_ready, rq_ready})); // R6
    AST_RD_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rq_ready |-> !rd_wait_s); // R8
    AST_WR_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready || rr_ready) |-> !wr_wait_s); // R9
    AST_RR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_valid && !wr_wait_s && !link_frame) |-> rr_ready); // R7
    AST_SKIP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rd_wait_s && !link_frame && !rr_valid && !wr_valid) |-> rq_ready); // R10
    AST_BYTE0_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_ready || wr_ready || rq_ready) |=> $rose(link_frame)); // R12

endmodule

// File: tb/link_tx_bench.sv
`timescale 1ns/1ps
module link_tx_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rr_valid = 0, wr_valid = 0, rq_valid = 0;
    logic         rr_ready, wr_ready, rq_ready;
    logic [103:0] rr_txn = '0, wr_txn = '0, rq_txn = '0;
    logic         rd_wait_async = 0, wr_wait_async = 0;
    logic         link_frame;
    logic [7:0]   link_byte;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    link_tx u_link_tx (
        .clk(clk), .rst_n(rst_n),
        .rr_valid(rr_valid), .rr_ready(rr_ready), .rr_txn(rr_txn),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_txn(wr_txn),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_txn(rq_txn),
        .rd_wait_async(rd_wait_async), .wr_wait_async(wr_wait_async),
        .link_frame(link_frame), .link_byte(link_byte)
    );

    // ---------------- capture monitor ----------------
    logic [7:0] cap_b [64][13];
    int cap_len [64];
    int cap_n = 0, cur_len = 0, gap = 0, min_gap = 1000;
    int multi_ready = 0, rr_seen = 0, wr_seen = 0, rq_seen = 0;
    logic prev_frame = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones({rr_ready, wr_ready, rq_ready}) > 1) multi_ready++;
            if (rr_ready) rr_seen++;
            if (wr_ready) wr_seen++;
            if (rq_ready) rq_seen++;
            if (link_frame) begin
                if (!prev_frame) begin
                    cur_len = 0;
                    if (cap_n > 0 && gap < min_gap) min_gap = gap;
                end
                if (cur_len < 13 && cap_n < 64) cap_b[cap_n][cur_len] = link_byte;
                cur_len++;
            end else begin
                if (prev_frame && cap_n < 64) begin
                    cap_len[cap_n] = cur_len;
                    cap_n++;
                    gap = 0;
                end
                gap++;
            end
            prev_frame = link_frame;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [103:0] mk(input logic wr, input logic [1:0] dm, input logic [3:0] cm,
                                        input logic [31:0] dst, input logic [31:0] dat, input logic [31:0] src);
        return {src, dat, dst, cm, dm, wr, 1'b1};
    endfunction

    function automatic bit is_long(input logic [103:0] t);
        return t[1] && (t[3:2] == 2'b11);
    endfunction

    function automatic logic [7:0] eb(input logic [103:0] t, input int k);
        logic [31:0] dst, dat, src, mid;
        dst = t[39:8]; dat = t[71:40]; src = t[103:72];
        mid = t[1] ? dat : src;
        if (k == 0)      return {t[7:4], t[3:2], t[1], is_long(t)};
        else if (k <= 4) return dst[8*(4-k) +: 8];
        else if (k <= 8) return mid[8*(8-k) +: 8];
        else             return src[8*(12-k) +: 8];
    endfunction

    task automatic check_pkt(input int idx, input logic [103:0] t, input string req);
        int exp_len;
        int bad;
        exp_len = is_long(t) ? 13 : 9;
        check(cap_n > idx, {req, " packet present"}, cap_n, idx + 1);
        if (cap_n > idx) begin
            check(cap_len[idx] == exp_len, {req, " length"}, cap_len[idx], exp_len);
            bad = -1;
            for (int k = 0; k < exp_len && k < 13; k++)
                if (bad < 0 && cap_b[idx][k] !== eb(t, k)) bad = k;
            if (bad >= 0) check(0, {req, " byte mismatch"}, cap_b[idx][bad], eb(t, bad));
            else          check(1, req, 0, 0);
        end
    endtask

    task automatic set_src(input int s, input logic v, input logic [103:0] t);
        case (s)
            0: begin rr_valid = v; rr_txn = t; end
            1: begin wr_valid = v; wr_txn = t; end
            default: begin rq_valid = v; rq_txn = t; end
        endcase
    endtask

    function automatic logic rdy(input int s);
        case (s)
            0: return rr_ready;
            1: return wr_ready;
            default: return rq_ready;
        endcase
    endfunction

    // Offer on a source, wait for acceptance, then check byte0 the next cycle (R12, R3)
    task automatic offer(input int s, input logic [103:0] t);
        set_src(s, 1'b1, t);
        forever begin
            #1;
            if (rdy(s)) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        check(link_frame === 1'b1 && link_byte === eb(t, 0), "R12 byte0 one cycle after accept",
              {link_frame, link_byte}, {1'b1, eb(t, 0)});
        set_src(s, 1'b0, '0);
    endtask

    task automatic wait_pkts(input int n);
        for (int i = 0; i < 200 && cap_n < n; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    logic [103:0] t_wr32, t_rq, t_wr64, t_rr, t_wr2, t_rq2;

    task automatic t_reset();
        #1;
        check(link_frame === 1'b0 && link_byte === 8'h00, "R1 outputs in reset", {link_frame, link_byte}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({rr_ready, wr_ready, rq_ready, link_frame} === 4'b0, "R1 idle after reset",
              {rr_ready, wr_ready, rq_ready, link_frame}, 0);
    endtask

    task automatic t_basic();
        int base;
        base = cap_n;
        offer(1, t_wr32); wait_pkts(base + 1);
        check_pkt(base, t_wr32, "R2 R4 32-bit write");
        offer(2, t_rq); wait_pkts(base + 2);
        check_pkt(base + 1, t_rq, "R4 read request carries return address");
        offer(1, t_wr64); wait_pkts(base + 3);
        check_pkt(base + 2, t_wr64, "R5 64-bit write 13 bytes");
    endtask

    task automatic t_priority();
        int base;
        base = cap_n;
        multi_ready = 0;
        min_gap = 1000;
        fork
            offer(2, t_rq2);
            offer(1, t_wr2);
            offer(0, t_rr);
        join
        wait_pkts(base + 3);
        check_pkt(base, t_rr, "R7 read response first");
        check_pkt(base + 1, t_wr2, "R7 write second");
        check_pkt(base + 2, t_rq2, "R7 read request last");
        check(min_gap >= 1, "R6 frame low between packets", min_gap, 1);
        check(multi_ready == 0, "R6 single ready", multi_ready, 0);
    endtask

    task automatic t_rd_sync();
        int base;
        base = cap_n;
        // One edge after wait rises: not yet effective
        rd_wait_async = 1'b1;
        @(negedge clk);
        rq_valid = 1'b1; rq_txn = t_rq;
        #1;
        check(rq_ready === 1'b1, "R8 wait not active after one edge", rq_ready, 1);
        @(posedge clk); @(negedge clk);
        rq_valid = 1'b0;
        wait_pkts(base + 1);
        check_pkt(base, t_rq, "R8 request sent before sync");
        rd_wait_async = 1'b0;
        repeat (4) @(negedge clk);
        // Two edges after wait rises: blocked; write proceeds instead
        rd_wait_async = 1'b1;
        @(negedge clk); @(negedge clk);
        rq_valid = 1'b1; rq_txn = t_rq2;
        #1;
        check(rq_ready === 1'b0, "R8 wait active after two edges", rq_ready, 0);
        rq_seen = 0;
        offer(1, t_wr2);
        wait_pkts(base + 2);
        repeat (15) @(negedge clk);
        check(rq_seen == 0, "R8 no read request while wait high", rq_seen, 0);
        check_pkt(base + 1, t_wr2, "R10 write skips blocked read");
        check(cap_n == base + 2, "R8 no extra packet", cap_n, base + 2);
        rd_wait_async = 1'b0;
        offer(2, t_rq2);
        wait_pkts(base + 3);
        check_pkt(base + 2, t_rq2, "R8 read sent after wait drops");
    endtask

    task automatic t_wr_wait();
        int base;
        base = cap_n;
        wr_wait_async = 1'b1;
        repeat (3) @(negedge clk);
        rr_valid = 1'b1; rr_txn = t_rr;
        wr_valid = 1'b1; wr_txn = t_wr32;
        rr_seen = 0; wr_seen = 0;
        offer(2, t_rq);
        wait_pkts(base + 1);
        repeat (15) @(negedge clk);
        check(rr_seen == 0 && wr_seen == 0, "R9 write class held", {rr_seen[15:0], wr_seen[15:0]}, 0);
        check_pkt(base, t_rq, "R10 read request skips blocked writes");
        check(cap_n == base + 1, "R9 nothing else sent", cap_n, base + 1);
        wr_wait_async = 1'b0;
        fork
            offer(0, t_rr);
            offer(1, t_wr32);
        join
        wait_pkts(base + 3);
        check_pkt(base + 1, t_rr, "R9 read response after release");
        check_pkt(base + 2, t_wr32, "R9 write after release");
    endtask

    task automatic t_inflight();
        int base;
        base = cap_n;
        offer(1, t_wr64);
        @(negedge clk);
        wr_wait_async = 1'b1;
        rd_wait_async = 1'b1;
        wait_pkts(base + 1);
        check_pkt(base, t_wr64, "R11 packet completes under wait");
        wr_wait_async = 1'b0;
        rd_wait_async = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- main ----------------
    initial begin
        t_wr32 = mk(1'b1, 2'b10, 4'h5, 32'h1122_3344, 32'hA1B2_C3D4, 32'h0BAD_F00D);
        t_rq   = mk(1'b0, 2'b10, 4'h0, 32'h8000_0010, 32'hDEAD_BEEF, 32'h4455_6677);
        t_wr64 = mk(1'b1, 2'b11, 4'hC, 32'hCAFE_0000, 32'h0102_0304, 32'hF0E0_D0C0);
        t_rr   = mk(1'b1, 2'b01, 4'h3, 32'h0000_4444, 32'h5566_7788, 32'h9999_AAAA);
        t_wr2  = mk(1'b1, 2'b00, 4'hA, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0F0F_0F0F);
        t_rq2  = mk(1'b0, 2'b11, 4'h9, 32'h7777_8888, 32'h1234_5678, 32'hABCD_EF01);
        t_reset();
        t_basic();
        t_priority();
        t_rd_sync();
        t_wr_wait();
        t_inflight();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule